// File: doc/BRIEF.md
# Repeat Loop and Breakpoint PC Sequencer

This block picks the program counter that follows each issued instruction word. For every issued word it takes the word's PC, the branch outcome, the state of a hardware repeat loop, the breakpoint setup, the processor status word and any pending exception. It then registers the next PC, the updated repeat count and repeat flag, the updated status word and, when a breakpoint trap fires, the return PC and status word. The fetch unit reads the registered next PC. The execution units supply the branch and exception inputs.

PCs are word addresses. The byte address is the PC shifted left by two. Sources are resolved in a fixed order: an exception first, then a breakpoint trap, then a taken branch, then a loop-back at the loop end, and last the sequential increment. All outputs move together on the clock edge at which `issue` is high. In every other cycle they hold.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc_next` is 0xFFC0 (byte address 0xFFC0 << 2). `rpt_cnt_out`, `rpt_on_out`, `psw_out`, `ret_pc` and `ret_psw` are all zero.
- R2: In a cycle with `issue` low, no output changes at the next edge.
- R3: An issued word with no exception, no breakpoint hit, no taken branch and no loop-back gives `pc_next = pc_in + 1`, wrapping modulo 2^AW. The count, the repeat flag and the status word pass through unchanged.
- R4: A taken branch with no exception and no breakpoint hit gives `pc_next = br_target`. The count, the repeat flag and the status word pass through.
- R5: With `rpt_on_in` set, `pc_in == rpt_end`, no taken branch, no exception, no breakpoint hit and `rpt_cnt_in > 1`, the block loads `pc_next = rpt_start` and `rpt_cnt_out = rpt_cnt_in - 1`, and keeps the repeat flag set.
- R6: The same loop-end condition with `rpt_cnt_in <= 1` ends the loop. `rpt_on_out` goes to 0, `pc_next = pc_in + 1` and the count passes through unchanged.
- R7: A taken branch at the loop-end address wins over the loop-back. The PC goes to the target and neither the count nor the flag changes.
- R8: With `dbg_en` high, `pc_in == brk_addr` and no exception, a breakpoint trap overrides any branch or loop-back. It sets `pc_next = 0xFFF4`, keeps only status bit 15 (stack mode) in `psw_out`, and stores `ret_pc = pc_in` and `ret_psw = psw_in`. The count and the flag pass through.
- R9: `exc_addr` gives `pc_next = 0xFFEC`. `exc_illegal` alone gives `pc_next = 0xFFE4`. `exc_addr` wins when both are set. Either exception overrides a breakpoint, branch or loop-back. `psw_out` keeps only bits 3 (F0), 2 (F1) and 0 (carry). The count and the flag pass through.
- R10: `ret_pc` and `ret_psw` change only on a breakpoint trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction word completes this cycle |
| pc_in | input | AW | Word address of the issued word |
| br_taken | input | 1 | The word redirected the PC |
| br_target | input | AW | Branch target word address |
| rpt_on_in | input | 1 | Repeat loop active |
| rpt_start | input | AW | Loop first word address |
| rpt_end | input | AW | Loop last word address |
| rpt_cnt_in | input | CW | Remaining iteration count |
| dbg_en | input | 1 | Breakpoint compare enabled |
| brk_addr | input | AW | Breakpoint word address |
| psw_in | input | PW | Current status word |
| exc_addr | input | 1 | Address-error exception |
| exc_illegal | input | 1 | Illegal-instruction exception |
| pc_next | output | AW | Next word address |
| rpt_cnt_out | output | CW | Updated iteration count |
| rpt_on_out | output | 1 | Updated repeat flag |
| psw_out | output | PW | Updated status word |
| ret_pc | output | AW | Saved PC for trap return |
| ret_psw | output | PW | Saved status word for trap return |

## Verification
The assertions assume that every input is driven to a known value in each cycle after reset. They also assume that the request and address inputs are steady around the clock edge, because the properties compare `$past` input values with registered outputs. The bench drives all inputs only on the falling edge, holds them across the rising edge and samples outputs on the next falling edge. The bench sweeps every combination of the branch, loop-end match, repeat flag, breakpoint hit and exception inputs, over count values that straddle the final-iteration boundary.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 16,
  parameter logic [AW-1:0] RESET_PC = 16'hFFC0,
  parameter logic [AW-1:0] VEC_DBT  = 16'hFFF4,
  parameter logic [AW-1:0] VEC_AE   = 16'hFFEC,
  parameter logic [AW-1:0] VEC_RIE  = 16'hFFE4,
  parameter int SM_BIT = 15,
  parameter int F0_BIT = 3,
  parameter int F1_BIT = 2,
  parameter int C_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] pc_in,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          rpt_on_in,
  input  logic [AW-1:0] rpt_start,
  input  logic [AW-1:0] rpt_end,
  input  logic [CW-1:0] rpt_cnt_in,
  input  logic          dbg_en,
  input  logic [AW-1:0] brk_addr,
  input  logic [PW-1:0] psw_in,
  input  logic          exc_addr,
  input  logic          exc_illegal,
  output logic [AW-1:0] pc_next,
  output logic [CW-1:0] rpt_cnt_out,
  output logic          rpt_on_out,
  output logic [PW-1:0] psw_out,
  output logic [AW-1:0] ret_pc,
  output logic [PW-1:0] ret_psw
);

  localparam logic [PW-1:0] EXC_KEEP  = PW'((1 << F0_BIT) | (1 << F1_BIT) | (1 << C_BIT));
  localparam logic [PW-1:0] TRAP_KEEP = PW'(1 << SM_BIT);

  typedef enum logic [2:0] {SEL_SEQ, SEL_BR, SEL_LOOP, SEL_LAST, SEL_TRAP, SEL_EXC} sel_e;

  sel_e sel;

  wire exc_any = exc_addr | exc_illegal;
  wire brk_hit = dbg_en && (pc_in == brk_addr);
  wire at_end  = rpt_on_in && (pc_in == rpt_end);
  wire last_it = (rpt_cnt_in <= CW'(1));

  always_comb begin
    if (exc_any)       sel = SEL_EXC;
    else if (brk_hit)  sel = SEL_TRAP;
    else if (br_taken) sel = SEL_BR;
    else if (at_end)   sel = last_it ? SEL_LAST : SEL_LOOP;
    else               sel = SEL_SEQ;
  end

  logic [AW-1:0] pc_d;
  logic [CW-1:0] cnt_d;
  logic          on_d;
  logic [PW-1:0] psw_d;

  always_comb begin
    pc_d  = pc_in + AW'(1);
    cnt_d = rpt_cnt_in;
    on_d  = rpt_on_in;
    psw_d = psw_in;
    unique case (sel)
      SEL_EXC: begin
        pc_d  = exc_addr ? VEC_AE : VEC_RIE;
        psw_d = psw_in & EXC_KEEP;
      end
      SEL_TRAP: begin
        pc_d  = VEC_DBT;
        psw_d = psw_in & TRAP_KEEP;
      end
      SEL_BR:   pc_d = br_target;
      SEL_LOOP: begin
        pc_d  = rpt_start;
        cnt_d = rpt_cnt_in - CW'(1);
      end
      SEL_LAST: on_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_next     <= RESET_PC;
      rpt_cnt_out <= '0;
      rpt_on_out  <= 1'b0;
      psw_out     <= '0;
      ret_pc      <= '0;
      ret_psw     <= '0;
    end else if (issue) begin
      pc_next     <= pc_d;
      rpt_cnt_out <= cnt_d;
      rpt_on_out  <= on_d;
      psw_out     <= psw_d;
      if (sel == SEL_TRAP) begin
        ret_pc  <= pc_in;
        ret_psw <= psw_in;
      end
    end
  end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 16,
  parameter logic [AW-1:0] VEC_DBT = 16'hFFF4,
  parameter logic [AW-1:0] VEC_AE  = 16'hFFEC,
  parameter logic [AW-1:0] VEC_RIE = 16'hFFE4,
  parameter int SM_BIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [AW-1:0] pc_in,
  input logic          br_taken,
  input logic [AW-1:0] br_target,
  input logic          rpt_on_in,
  input logic [AW-1:0] rpt_start,
  input logic [AW-1:0] rpt_end,
  input logic [CW-1:0] rpt_cnt_in,
  input logic          dbg_en,
  input logic [AW-1:0] brk_addr,
  input logic [PW-1:0] psw_in,
  input logic          exc_addr,
  input logic          exc_illegal,
  input logic [AW-1:0] pc_next,
  input logic [CW-1:0] rpt_cnt_out,
  input logic          rpt_on_out,
  input logic [PW-1:0] psw_out,
  input logic [AW-1:0] ret_pc,
  input logic [PW-1:0] ret_psw
);

  wire exc_c  = exc_addr | exc_illegal;
  wire trap_c = !exc_c && dbg_en && (pc_in == brk_addr);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(pc_next) && $stable(rpt_cnt_out) && $stable(rpt_on_out) && $stable(psw_out));

  // R9
  addr_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && exc_addr |=> pc_next == VEC_AE);

  // R9
  ill_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && exc_illegal && !exc_addr |=> pc_next == VEC_RIE);

  // R8
  trap_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && trap_c |=> pc_next == VEC_DBT && ret_pc == $past(pc_in) && ret_psw == $past(psw_in)
      && psw_out == ($past(psw_in) & PW'(1 << SM_BIT)));

  // R10
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && trap_c) |=> $stable(ret_pc) && $stable(ret_psw));

  // R5
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !exc_c && !trap_c && !br_taken && rpt_on_in && pc_in == rpt_end && rpt_cnt_in > CW'(1)
      |=> pc_next == $past(rpt_start) && rpt_cnt_out == $past(rpt_cnt_in) - CW'(1) && rpt_on_out);

  // R7
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !exc_c && !trap_c && br_taken |=> pc_next == $past(br_target)
      && rpt_cnt_out == $past(rpt_cnt_in) && rpt_on_out == $past(rpt_on_in));

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .AW(AW), .CW(CW), .PW(PW), .VEC_DBT(VEC_DBT), .VEC_AE(VEC_AE), .VEC_RIE(VEC_RIE), .SM_BIT(SM_BIT)
) u_chk (.*);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;
  localparam int AW = 16, CW = 16, PW = 16;

  logic clk = 0, rst_n = 0, issue = 0;
  logic [AW-1:0] pc_in = 0, br_target = 0, rpt_start = 0, rpt_end = 0, brk_addr = 0;
  logic br_taken = 0, rpt_on_in = 0, dbg_en = 0, exc_addr = 0, exc_illegal = 0;
  logic [CW-1:0] rpt_cnt_in = 0;
  logic [PW-1:0] psw_in = 0;
  logic [AW-1:0] pc_next, ret_pc;
  logic [CW-1:0] rpt_cnt_out;
  logic rpt_on_out;
  logic [PW-1:0] psw_out, ret_psw;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pc_sequencer i_pc_sequencer (.*);

  logic [AW-1:0] e_pc, e_rpc;
  logic [CW-1:0] e_cnt;
  logic e_on;
  logic [PW-1:0] e_psw, e_rpsw;
  string e_req;

  task automatic compare(string req);
    n_chk++;
    if ({pc_next, rpt_cnt_out, rpt_on_out, psw_out, ret_pc, ret_psw} !==
        {e_pc, e_cnt, e_on, e_psw, e_rpc, e_rpsw}) begin
      n_bad++;
      $display("FAIL %s: pc=%h cnt=%h on=%b psw=%h rpc=%h rpsw=%h expected pc=%h cnt=%h on=%b psw=%h rpc=%h rpsw=%h",
        req, pc_next, rpt_cnt_out, rpt_on_out, psw_out, ret_pc, ret_psw,
        e_pc, e_cnt, e_on, e_psw, e_rpc, e_rpsw);
    end
  endtask

  task automatic model();
    e_cnt = rpt_cnt_in; e_on = rpt_on_in; e_psw = psw_in; e_pc = pc_in + 16'd1;
    if (exc_addr || exc_illegal) begin
      e_pc = exc_addr ? 16'hFFEC : 16'hFFE4;
      e_psw = psw_in & 16'h000D;
      e_req = "R9";
    end else if (dbg_en && pc_in == brk_addr) begin
      e_pc = 16'hFFF4; e_psw = psw_in & 16'h8000;
      e_rpc = pc_in; e_rpsw = psw_in;
      e_req = "R8";
    end else if (br_taken) begin
      e_pc = br_target;
      e_req = (rpt_on_in && pc_in == rpt_end) ? "R7" : "R4";
    end else if (rpt_on_in && pc_in == rpt_end) begin
      if (rpt_cnt_in > 1) begin e_pc = rpt_start; e_cnt = rpt_cnt_in - 1; e_req = "R5"; end
      else begin e_on = 0; e_req = "R6"; end
    end else e_req = "R3";
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    e_pc = 16'hFFC0; e_cnt = 0; e_on = 0; e_psw = 0; e_rpc = 0; e_rpsw = 0;
    compare("R1");
    rst_n = 1;

    for (int k = 0; k < 384; k++) begin
      logic [CW-1:0] cnts [6];
      cnts = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd7, 16'hFFFF};
      @(negedge clk);
      issue       = 1;
      br_taken    = k[0];
      rpt_on_in   = k[1];
      dbg_en      = k[2];
      exc_addr    = k[3];
      exc_illegal = k[4];
      rpt_cnt_in  = cnts[(k >> 5) % 6];
      pc_in       = (k % 7 == 6) ? 16'hFFFF : 16'h0100 + 16'(k * 3);
      rpt_end     = (k % 3 == 0) ? pc_in + 1 : pc_in;
      brk_addr    = (k % 5 == 1) ? pc_in - 2 : pc_in;
      br_target   = 16'h4000 + 16'(k);
      rpt_start   = 16'h0020 + 16'(k);
      psw_in      = 16'hA5C3 ^ 16'(k * 16'h0111);
      model();
      @(negedge clk);
      compare(e_req);
      issue = 0;
      pc_in = pc_in ^ 16'h00F0; exc_addr = ~exc_addr; dbg_en = 1; brk_addr = pc_in;
      psw_in = ~psw_in; rpt_cnt_in = rpt_cnt_in + 5;
      @(negedge clk);
      compare("R2 R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule